// File: doc/BRIEF.md
# Fall-Through FIFO with Ready Flags

This block is a first-in/first-out buffer of 64 words of 4 bits. Words are held in a dual-port memory that a write pointer and a read pointer address. No chain of shift registers is used. A word stored into an empty buffer goes to the output port without any read action. An output-ready flag marks it as valid. A shift-out strobe consumes the head word, and the next stored word then becomes visible. On the write side, an input-ready flag shows whether the buffer can accept another word.

The strobes are sampled on the rising edge of the single clock. A transfer happens in any cycle in which a strobe is high and its matching flag is high, so a strobe may also be held high as a level. Because of this, the buffers chain without extra logic:

- **Depth:** the upstream output-ready drives the downstream shift-in, the downstream input-ready drives the upstream shift-out, and the data output feeds the data input.
- **Width:** buffers sit side by side, and their input-ready flags are ANDed, as are their output-ready flags.

An output-enable input forces the data output to an idle value of zero. An active-low master reset empties the buffer at any time.

Top module: `shift_fifo`

## Requirements
- R1: While reset is low and in the first cycle after it is released, in_rdy is 1, out_rdy is 0 and dout is 0.
- R2: Words leave in the order they were accepted, and exactly 64 words are accepted before in_rdy falls.
- R3: A shift_in in a cycle where in_rdy is 0 stores nothing, even when shift_out is high in the same cycle; the stored contents and their order are unchanged.
- R4: A shift_out in a cycle where out_rdy is 0 removes nothing, even when shift_in is high in the same cycle.
- R5: A word shifted into an empty buffer appears on dout with out_rdy = 1 in the next cycle, with no shift_out needed.
- R6: shift_in and shift_out in the same cycle, with both flags high, leave the occupancy unchanged and keep the order of the words.
- R7: dout is 0 whenever out_en is 0 or out_rdy is 0; out_en has no effect on the stored words.
- R8: out_rdy is 0 exactly when the buffer holds no word, and in_rdy is 0 exactly when it holds 64 words; out_rdy rises only after a cycle with shift_in high.
- R9: Pulling rst_n low in the middle of operation empties the buffer at once: in_rdy becomes 1, out_rdy becomes 0 and dout becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all transfers happen on its rising edge |
| rst_n | input | 1 | Master reset, active low, asynchronous; empties the buffer |
| din | input | 4 | Word to store |
| shift_in | input | 1 | Store din this cycle if in_rdy is high |
| in_rdy | output | 1 | High when a word can be accepted, low when full |
| dout | output | 4 | Head word, gated by out_en and out_rdy |
| shift_out | input | 1 | Consume the head word this cycle if out_rdy is high |
| out_rdy | output | 1 | High when dout holds a valid word, low when empty |
| out_en | input | 1 | High drives the head word onto dout; low forces 0 |

## Verification
A wrong pointer or occupancy state shows up at the ports in one of two ways. The flags can become wrong: in_rdy can fall before the 64th word or stay high past it, and out_rdy can stay high when the buffer is empty. Or dout can show a word out of order, repeated, or skipped. Both faults appear at the latest when the affected word reaches the head. Flag errors show in the cycle right after the faulty transfer. To expose them quickly, the stimulus often drives the buffer to full and to empty, and it hits both the full and the empty boundary with simultaneous strobes.

// File: rtl/shift_fifo_pkg.sv
package shift_fifo_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2,
        OP_SWAP = 2'd3
    } fifo_op_e;

    function automatic fifo_op_e classify(input logic push, input logic pop);
        fifo_op_e op;
        case ({pop, push})
            2'b01:   op = OP_PUSH;
            2'b10:   op = OP_POP;
            2'b11:   op = OP_SWAP;
            default: op = OP_HOLD;
        endcase
        return op;
    endfunction

endpackage

// File: rtl/shift_fifo_mem.sv
module shift_fifo_mem #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] store_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/shift_fifo_ctrl.sv
module shift_fifo_ctrl
    import shift_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_in,
    input  logic          shift_out,
    output logic          we,
    output logic [AW-1:0] waddr,
    output logic [AW-1:0] raddr,
    output logic          in_rdy,
    output logic          out_rdy,
    output logic [CW-1:0] level
);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
        logic          room;
        logic          avail;
    } ctrl_state_t;

    localparam ctrl_state_t RESET_STATE = '{
        wr_ptr: '0, rd_ptr: '0, cnt: '0, room: 1'b1, avail: 1'b0
    };

    ctrl_state_t st_d, st_q;
    logic        push_ok;
    logic        pop_ok;
    fifo_op_e    op;

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        push_ok = shift_in && st_q.room;
        pop_ok  = shift_out && st_q.avail;
        op      = classify(push_ok, pop_ok);
        case (op)
            OP_PUSH: begin
                st_d.wr_ptr = ptr_next(st_q.wr_ptr);
                st_d.cnt    = st_q.cnt + CW'(1);
            end
            OP_POP: begin
                st_d.rd_ptr = ptr_next(st_q.rd_ptr);
                st_d.cnt    = st_q.cnt - CW'(1);
            end
            OP_SWAP: begin
                st_d.wr_ptr = ptr_next(st_q.wr_ptr);
                st_d.rd_ptr = ptr_next(st_q.rd_ptr);
            end
            default: begin
            end
        endcase
        st_d.room  = (st_d.cnt != CW'(DEPTH));
        st_d.avail = (st_d.cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RESET_STATE;
        end else begin
            st_q <= st_d;
        end
    end

    assign we      = push_ok;
    assign waddr   = st_q.wr_ptr;
    assign raddr   = st_q.rd_ptr;
    assign in_rdy  = st_q.room;
    assign out_rdy = st_q.avail;
    assign level   = st_q.cnt;

endmodule

// File: rtl/shift_fifo_outgate.sv
module shift_fifo_outgate #(
    parameter int               WIDTH = 4,
    parameter logic [WIDTH-1:0] IDLE  = '0
) (
    input  logic             enable,
    input  logic             valid,
    input  logic [WIDTH-1:0] head,
    output logic [WIDTH-1:0] dout
);

    always_comb begin
        if (enable && valid) begin
            dout = head;
        end else begin
            dout = IDLE;
        end
    end

endmodule

// File: rtl/shift_fifo.sv
module shift_fifo #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             shift_in,
    output logic             in_rdy,
    output logic [WIDTH-1:0] dout,
    input  logic             shift_out,
    output logic             out_rdy,
    input  logic             out_en
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic             we;
    logic [AW-1:0]    waddr;
    logic [AW-1:0]    raddr;
    logic [WIDTH-1:0] head;
    logic [CW-1:0]    level;

    shift_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_in  (shift_in),
        .shift_out (shift_out),
        .we        (we),
        .waddr     (waddr),
        .raddr     (raddr),
        .in_rdy    (in_rdy),
        .out_rdy   (out_rdy),
        .level     (level)
    );

    shift_fifo_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (we),
        .waddr (waddr),
        .wdata (din),
        .raddr (raddr),
        .rdata (head)
    );

    shift_fifo_outgate #(.WIDTH(WIDTH), .IDLE('0)) u_gate (
        .enable (out_en),
        .valid  (out_rdy),
        .head   (head),
        .dout   (dout)
    );

endmodule

// File: rtl/shift_fifo_checker.sv
module shift_fifo_checker #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] din,
    input logic             shift_in,
    input logic             in_rdy,
    input logic [WIDTH-1:0] dout,
    input logic             shift_out,
    input logic             out_rdy,
    input logic             out_en,
    input logic [CW-1:0]    level
);

    // R3: refused push while full keeps the buffer full and the level unchanged
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_rdy && shift_in && !shift_out) |=> (!in_rdy && $stable(level)));

    // R4: refused pop while empty keeps the buffer empty
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_rdy && shift_out && !shift_in) |=> (!out_rdy && $stable(level)));

    // R5: a word written into an empty buffer falls through next cycle
    p_fall_through_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_rdy && shift_in && in_rdy) |=>
            (out_rdy && (!out_en || dout == $past(din))));

    // R6: simultaneous accepted push and pop keep the level
    p_swap_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_in && in_rdy && shift_out && out_rdy) |=> $stable(level));

    // R7: output idles when disabled or invalid
    p_idle_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en || !out_rdy) |-> (dout == '0));

    // R8: output-ready only rises after a shift-in
    p_rise_needs_push_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_rdy) |-> $past(shift_in));

    // R8: flags agree with the level
    p_flags_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy == (level != '0)) && (in_rdy == (level != CW'(DEPTH))));

endmodule

bind shift_fifo shift_fifo_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .shift_in  (shift_in),
    .in_rdy    (in_rdy),
    .dout      (dout),
    .shift_out (shift_out),
    .out_rdy   (out_rdy),
    .out_en    (out_en),
    .level     (level)
);

// File: tb/shift_fifo_bench.sv
`timescale 1ns/1ps
module shift_fifo_bench;

    localparam int DEPTH = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] din = '0;
    logic       shift_in = 1'b0;
    logic       shift_out = 1'b0;
    logic       out_en = 1'b1;
    logic       in_rdy;
    logic       out_rdy;
    logic [3:0] dout;

    int         tests = 0;
    int         fails = 0;
    bit         done = 1'b0;
    logic [3:0] model [$];

    always #5 clk = ~clk;

    shift_fifo u_shift_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .din       (din),
        .shift_in  (shift_in),
        .in_rdy    (in_rdy),
        .dout      (dout),
        .shift_out (shift_out),
        .out_rdy   (out_rdy),
        .out_en    (out_en)
    );

    function automatic logic exp_in_rdy();
        return model.size() < DEPTH;
    endfunction

    function automatic logic exp_out_rdy();
        return model.size() > 0;
    endfunction

    function automatic logic [3:0] exp_dout(input logic oe);
        return (oe && model.size() > 0) ? model[0] : 4'h0;
    endfunction

    task automatic chk(input string what, input logic [3:0] act, input logic [3:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic check_ports(input string tag);
        chk({tag, " in_rdy"},  {3'b0, in_rdy},  {3'b0, exp_in_rdy()});
        chk({tag, " out_rdy"}, {3'b0, out_rdy}, {3'b0, exp_out_rdy()});
        chk({tag, " dout"},    dout,            exp_dout(out_en));
    endtask

    // Drive one cycle of stimulus; checks outputs before the edge, updates model after it.
    task automatic step(input logic si, input logic so, input logic [3:0] d,
                        input logic oe, input string tag);
        logic push;
        logic pop;
        shift_in  = si;
        shift_out = so;
        din       = d;
        out_en    = oe;
        #1;
        check_ports(tag);
        push = si && exp_in_rdy();
        pop  = so && exp_out_rdy();
        @(posedge clk);
        if (pop) begin
            void'(model.pop_front());
        end
        if (push) begin
            model.push_back(d);
        end
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1729));
        repeat (3) @(negedge clk);
        #1;
        check_ports("R1 in reset");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 4'h0, 1'b1, "R1 after release");

        // R5: fall-through into empty
        step(1'b1, 1'b0, 4'hA, 1'b1, "R5 write");
        step(1'b0, 1'b0, 4'h0, 1'b1, "R5 head visible");
        step(1'b0, 1'b1, 4'h0, 1'b1, "R5 consume");

        // R4: pops while empty
        step(1'b0, 1'b1, 4'h0, 1'b1, "R4 pop empty");
        step(1'b0, 1'b1, 4'h0, 1'b1, "R4 pop empty");
        step(1'b1, 1'b1, 4'h3, 1'b1, "R4 pop+push empty");
        step(1'b0, 1'b0, 4'h0, 1'b1, "R4 new head");
        step(1'b0, 1'b1, 4'h0, 1'b1, "R4 drain");

        // R2: fill to capacity
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b1, 1'b0, 4'(i) ^ 4'h5, 1'b1, "R2 fill");
        end
        step(1'b0, 1'b0, 4'h0, 1'b1, "R8 full flag");

        // R3: pushes while full
        step(1'b1, 1'b0, 4'hF, 1'b1, "R3 push full");
        step(1'b1, 1'b0, 4'hF, 1'b1, "R3 push full");
        step(1'b1, 1'b1, 4'hE, 1'b1, "R3 push+pop full");
        step(1'b1, 1'b0, 4'hD, 1'b1, "R3 refill");
        step(1'b0, 1'b0, 4'h0, 1'b1, "R3 full again");

        // R7: drain with output enable toggling
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 1'b0, 4'h0, 1'b0, "R7 oe low hold");
            step(1'b0, 1'b1, 4'h0, 1'(i % 2), "R7 drain");
        end
        step(1'b0, 1'b0, 4'h0, 1'b1, "R8 empty flag");

        // R6: simultaneous push and pop mid-level
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 1'b0, 4'(i), 1'b1, "R6 prefill");
        end
        for (int i = 0; i < 20; i++) begin
            step(1'b1, 1'b1, 4'($urandom), 1'b1, "R6 swap");
        end

        // R9: reset in the middle of operation
        shift_in  = 1'b0;
        shift_out = 1'b0;
        rst_n     = 1'b0;
        #1;
        model.delete();
        check_ports("R9 mid reset");
        @(negedge clk);
        rst_n = 1'b1;
        step(1'b0, 1'b0, 4'h0, 1'b1, "R9 after release");

        // R2/R8: random traffic with alternating bias toward full and empty
        for (int k = 0; k < 4000; k++) begin
            int bias;
            bias = ((k / 300) % 2 == 0) ? 80 : 20;
            step(1'(($urandom % 100) < bias), 1'(($urandom % 100) >= bias),
                 4'($urandom), 1'(($urandom % 8) != 0), "R2 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule